// File: doc/BRIEF.md
# Parallel Port Reverse-Channel Receiver (Host Side)

This block sits on the host end of an extended-capabilities parallel link and handles the peripheral-to-host direction. On a start request it stops driving the shared eight-bit data bus. It then asks the peripheral to reverse the link and waits for the peripheral to grant the request. After the grant it takes in bytes through a four-phase interlock. The peripheral drops its strobe line to show that a byte is valid. The host raises its acknowledge. The byte and its type are captured when the strobe rises again, and the host lowers its acknowledge when it can take the next byte.

Each captured byte goes out on a ready/valid stream together with a command flag. While the stream is not ready, the host keeps its acknowledge high, which stalls the peripheral. A stop request, seen between bytes, releases the reverse request. The data bus is driven again only after the peripheral withdraws its grant. Every peripheral input passes through a two-flop synchroniser. A programmable cycle limit bounds each wait on the peripheral. If the limit runs out, a sticky error flag is set and the block falls back to forward idle.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, `rev_req_n_o`=1, `host_ack_o`=0, `data_oe_o`=1, `m_valid_o`=0 and `err_o`=0.
- R2: A `start_i` pulse seen in forward idle drops `data_oe_o` one cycle before `rev_req_n_o` goes low. `data_oe_o` stays 0 whenever `rev_req_n_o` is 0.
- R3: Until the synchronised `grant_n_i` is low, peripheral strobe activity does not raise `host_ack_o` and does not produce a stream beat.
- R4: Three clock edges after the peripheral strobe `pclk_i` falls (two synchroniser stages plus the state register), with the grant in place, `host_ack_o` goes to 1.
- R5: When `pclk_i` rises, the byte on `data_i` is captured and later presented on `m_data_o` with `m_valid_o`=1. `m_cmd_o` is 1 when `pack_i` was low (command) and 0 when it was high (data).
- R6: While `m_valid_o`=1 and `m_ready_i`=0, the beat stays valid with unchanged data and flag, and `host_ack_o` stays 1. The cycle after the handshake, `m_valid_o` and `host_ack_o` are both 0.
- R7: If `stop_i` is high while the block waits between bytes, `rev_req_n_o` returns to 1. `data_oe_o` returns to 1 only after the synchronised `grant_n_i` is high again.
- R8: With `tmo_lim_i`=L (L>0), a wait that lasts L cycles sets `err_o` and returns the block to forward idle (`rev_req_n_o`=1, `data_oe_o`=1). The waits counted are: for the grant, for the strobe to rise, for the grant to be withdrawn, and for a strobe while `preq_n_i` is low. L=0 disables the timeout.
- R9: `err_o` stays 1 until the next accepted `start_i`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to enter reverse mode (sampled in forward idle) |
| stop_i | input | 1 | Request to leave reverse mode (level, sampled between bytes) |
| tmo_lim_i | input | TMO_W | Wait limit in cycles, 0 = no timeout |
| pclk_i | input | 1 | Peripheral strobe, low = byte valid |
| pack_i | input | 1 | Peripheral byte type, high = data, low = command |
| grant_n_i | input | 1 | Peripheral grant of reverse direction, active low |
| preq_n_i | input | 1 | Peripheral has reverse data waiting, active low |
| data_i | input | DATA_W | Data bus as seen at the pins |
| data_oe_o | output | 1 | Host drives the data bus when 1 |
| rev_req_n_o | output | 1 | Reverse-direction request, active low |
| host_ack_o | output | 1 | Host acknowledge of the reverse byte |
| m_valid_o | output | 1 | Stream beat valid |
| m_ready_i | input | 1 | Stream consumer ready |
| m_data_o | output | DATA_W | Stream byte |
| m_cmd_o | output | 1 | Stream beat is a command byte |
| err_o | output | 1 | Sticky timeout flag |

## Verification
The assertions assume the peripheral keeps to its side of the interlock. It moves its strobe only while the grant is in place and the host acknowledge allows it, and it holds byte and type steady from before the strobe falls until the acknowledge drops. The stimulus is a bench-side peripheral model that changes its lines only at falling clock edges. It sets data and type one cycle ahead of the strobe and waits on `host_ack_o` at each phase. The only strobe activity it makes outside this protocol is a deliberate pulse before the grant, used to show that such activity is ignored. The stream consumer holds ready low for a varying number of cycles, so that stalls of zero to three cycles appear across a sweep of all 256 byte values with mixed types.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;

  typedef enum logic [2:0] {
    ST_FWD,        // forward idle, host owns the bus
    ST_FLOAT,      // bus released, request not yet raised
    ST_REQ,        // reverse requested, waiting for grant
    ST_WAIT_BYTE,  // between bytes, waiting for strobe low
    ST_WAIT_RISE,  // acknowledge high, waiting for strobe high
    ST_PUSH,       // beat offered on stream, acknowledge held
    ST_RELEASE     // request dropped, waiting for grant withdrawal
  } rev_state_e;

  // Timeout due when the count reaches limit-1; a zero limit never expires.
  function automatic logic tmo_due(input logic [31:0] cnt, input logic [31:0] lim);
    return (lim != 32'd0) && ((cnt + 32'd1) >= lim);
  endfunction

  // Type line high marks data, low marks a command.
  function automatic logic beat_is_cmd(input logic type_level);
    return !type_level;
  endfunction

  function automatic logic holds_request(input rev_state_e s);
    return (s == ST_REQ) || (s == ST_WAIT_BYTE) || (s == ST_WAIT_RISE) || (s == ST_PUSH);
  endfunction

  function automatic logic drives_ack(input rev_state_e s);
    return (s == ST_WAIT_RISE) || (s == ST_PUSH);
  endfunction

endpackage

// File: rtl/ecp_rev_sync.sv
module ecp_rev_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ecp_rev_timer.sv
module ecp_rev_timer #(
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [TMO_W-1:0] lim,
  output logic             expired
);
  import ecp_rev_pkg::*;

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr || !run)    cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && tmo_due(32'(cnt_q), 32'(lim));
endmodule

// File: rtl/ecp_rev_fsm.sv
module ecp_rev_fsm #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              pclk_s,
  input  logic              pack_s,
  input  logic              grant_n_s,
  input  logic              preq_n_s,
  input  logic [DATA_W-1:0] pdata_s,
  input  logic              m_ready_i,
  input  logic              tmo,
  output logic              state_chg,
  output logic              wait_run,
  output logic              cap_evt,
  output logic              rev_req_n_o,
  output logic              host_ack_o,
  output logic              data_oe_o,
  output logic              m_valid_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_cmd_o,
  output logic              err_o
);
  import ecp_rev_pkg::*;

  rev_state_e        state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic              cmd_q;
  logic              err_q;
  logic              start_acc;

  always_comb begin
    state_d   = state_q;
    cap_evt   = 1'b0;
    start_acc = 1'b0;
    unique case (state_q)
      ST_FWD: begin
        if (start_i) begin
          state_d   = ST_FLOAT;
          start_acc = 1'b1;
        end
      end
      ST_FLOAT: state_d = ST_REQ;
      ST_REQ: begin
        if (tmo)             state_d = ST_FWD;
        else if (!grant_n_s) state_d = ST_WAIT_BYTE;
      end
      ST_WAIT_BYTE: begin
        if (tmo)          state_d = ST_FWD;
        else if (!pclk_s) state_d = ST_WAIT_RISE;
        else if (stop_i)  state_d = ST_RELEASE;
      end
      ST_WAIT_RISE: begin
        if (tmo) state_d = ST_FWD;
        else if (pclk_s) begin
          state_d = ST_PUSH;
          cap_evt = 1'b1;
        end
      end
      ST_PUSH: begin
        if (m_ready_i) state_d = ST_WAIT_BYTE;
      end
      ST_RELEASE: begin
        if (tmo || grant_n_s) state_d = ST_FWD;
      end
      default: state_d = ST_FWD;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_REQ, ST_WAIT_RISE, ST_RELEASE: wait_run = 1'b1;
      ST_WAIT_BYTE:                     wait_run = !preq_n_s;
      default:                          wait_run = 1'b0;
    endcase
  end

  assign state_chg = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FWD;
      data_q  <= '0;
      cmd_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap_evt) begin
        data_q <= pdata_s;
        cmd_q  <= beat_is_cmd(pack_s);
      end
      if (tmo)            err_q <= 1'b1;
      else if (start_acc) err_q <= 1'b0;
    end
  end

  assign rev_req_n_o = !holds_request(state_q);
  assign host_ack_o  = drives_ack(state_q);
  assign data_oe_o   = (state_q == ST_FWD);
  assign m_valid_o   = (state_q == ST_PUSH);
  assign m_data_o    = data_q;
  assign m_cmd_o     = cmd_q;
  assign err_o       = err_q;
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx #(
  parameter int DATA_W   = 8,
  parameter int TMO_W    = 12,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [TMO_W-1:0]  tmo_lim_i,
  input  logic              pclk_i,
  input  logic              pack_i,
  input  logic              grant_n_i,
  input  logic              preq_n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              data_oe_o,
  output logic              rev_req_n_o,
  output logic              host_ack_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_cmd_o,
  output logic              err_o
);
  localparam int CTL_W = 4;
  // control bit order: strobe, type, grant_n, request_n (idle levels 1,0,1,1)
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1011;

  logic [CTL_W-1:0]  ctl_s;
  logic [DATA_W-1:0] pdata_s;
  logic              pclk_s, pack_s, grant_n_s, preq_n_s;
  logic              tmo, state_chg, wait_run, cap_evt;

  ecp_rev_sync #(.W(CTL_W), .STAGES(SYNC_STG), .RST_VAL(CTL_IDLE)) u_sync_ctl (
    .clk (clk), .rst_n (rst_n),
    .d   ({pclk_i, pack_i, grant_n_i, preq_n_i}),
    .q   (ctl_s)
  );

  ecp_rev_sync #(.W(DATA_W), .STAGES(SYNC_STG), .RST_VAL('0)) u_sync_dat (
    .clk (clk), .rst_n (rst_n), .d (data_i), .q (pdata_s)
  );

  assign pclk_s    = ctl_s[3];
  assign pack_s    = ctl_s[2];
  assign grant_n_s = ctl_s[1];
  assign preq_n_s  = ctl_s[0];

  ecp_rev_timer #(.TMO_W(TMO_W)) u_timer (
    .clk (clk), .rst_n (rst_n), .clr (state_chg), .run (wait_run),
    .lim (tmo_lim_i), .expired (tmo)
  );

  ecp_rev_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .stop_i (stop_i),
    .pclk_s (pclk_s), .pack_s (pack_s), .grant_n_s (grant_n_s), .preq_n_s (preq_n_s),
    .pdata_s (pdata_s), .m_ready_i (m_ready_i), .tmo (tmo),
    .state_chg (state_chg), .wait_run (wait_run), .cap_evt (cap_evt),
    .rev_req_n_o (rev_req_n_o), .host_ack_o (host_ack_o), .data_oe_o (data_oe_o),
    .m_valid_o (m_valid_o), .m_data_o (m_data_o), .m_cmd_o (m_cmd_o), .err_o (err_o)
  );
endmodule

// File: rtl/ecp_rev_chk.sv
module ecp_rev_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rev_req_n_o,
  input logic              host_ack_o,
  input logic              data_oe_o,
  input logic              m_valid_o,
  input logic              m_ready_i,
  input logic [DATA_W-1:0] m_data_o,
  input logic              m_cmd_o,
  input logic              err_o,
  input logic              grant_n_s,
  input logic              cap_evt
);
  p_bus_off_at_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rev_req_n_o) |-> !data_oe_o && $past(!data_oe_o));

  p_bus_off_in_reverse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rev_req_n_o |-> !data_oe_o);

  p_ack_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack_o) |-> !grant_n_s);

  p_capture_offers_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> m_valid_o);

  p_beat_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_cmd_o));

  p_ack_high_while_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o |-> host_ack_o);

  p_redrive_after_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) && !$rose(err_o) |-> grant_n_s && rev_req_n_o);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !start_i |=> err_o);
endmodule

bind ecp_rev_rx ecp_rev_chk #(.DATA_W(DATA_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .start_i (start_i), .rev_req_n_o (rev_req_n_o),
  .host_ack_o (host_ack_o), .data_oe_o (data_oe_o), .m_valid_o (m_valid_o),
  .m_ready_i (m_ready_i), .m_data_o (m_data_o), .m_cmd_o (m_cmd_o), .err_o (err_o),
  .grant_n_s (grant_n_s), .cap_evt (cap_evt)
);

// File: tb/ecp_rev_rx_tb_top.sv
module ecp_rev_rx_tb_top;
  localparam int DW = 8;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, stop_i = 1'b0;
  logic [TW-1:0] tmo_lim_i = '0;
  logic          pclk_i = 1'b1, pack_i = 1'b0, grant_n_i = 1'b1, preq_n_i = 1'b1;
  logic [DW-1:0] data_i = '0;
  logic          data_oe_o, rev_req_n_o, host_ack_o, m_valid_o, m_cmd_o, err_o;
  logic          m_ready_i = 1'b0;
  logic [DW-1:0] m_data_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  ecp_rev_rx #(.DATA_W(DW), .TMO_W(TW)) dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .stop_i (stop_i),
    .tmo_lim_i (tmo_lim_i), .pclk_i (pclk_i), .pack_i (pack_i),
    .grant_n_i (grant_n_i), .preq_n_i (preq_n_i), .data_i (data_i),
    .data_oe_o (data_oe_o), .rev_req_n_o (rev_req_n_o), .host_ack_o (host_ack_o),
    .m_valid_o (m_valid_o), .m_ready_i (m_ready_i), .m_data_o (m_data_o),
    .m_cmd_o (m_cmd_o), .err_o (err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    tick(1);
    start_i = 1'b0;
  endtask

  // Peripheral sends one byte; consumer stalls for 'stall' cycles.
  task automatic send_byte(input logic [DW-1:0] d, input bit cmd, input int stall);
    int k;
    bit ok;
    data_i = d;
    pack_i = !cmd;
    tick(1);
    pclk_i = 1'b0;
    k = 0;
    while (host_ack_o !== 1'b1 && k < 50) begin tick(1); k++; end
    check(k == 3, "R4 ack latency", k, 3);
    pclk_i = 1'b1;
    k = 0;
    while (m_valid_o !== 1'b1 && k < 50) begin tick(1); k++; end
    check(m_data_o == d && m_cmd_o == cmd, "R5 captured byte/type",
          int'({m_cmd_o, m_data_o}), int'({cmd, d}));
    ok = 1'b1;
    for (int s = 0; s < stall; s++) begin
      tick(1);
      if (!(m_valid_o && host_ack_o && m_data_o == d)) ok = 1'b0;
    end
    if (stall > 0) check(ok, "R6 beat held during stall", int'(ok), 1);
    m_ready_i = 1'b1;
    tick(1);
    m_ready_i = 1'b0;
    check(!m_valid_o && !host_ack_o, "R6 release after handshake",
          int'({m_valid_o, host_ack_o}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int k;
    bit ok;
    tick(4);
    check(rev_req_n_o && !host_ack_o && data_oe_o && !m_valid_o && !err_o, "R1 reset state",
          int'({rev_req_n_o, host_ack_o, data_oe_o, m_valid_o, err_o}), 5'b10100);
    rst_n = 1'b1;
    tick(3);

    // R2: bus released one cycle before the request
    pulse_start();
    check(!data_oe_o && rev_req_n_o, "R2 bus off before request",
          int'({data_oe_o, rev_req_n_o}), 1);
    tick(1);
    check(!data_oe_o && !rev_req_n_o, "R2 request raised with bus off",
          int'({data_oe_o, rev_req_n_o}), 0);

    // R3: strobe activity before grant is ignored
    pclk_i = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (host_ack_o || m_valid_o) ok = 1'b0;
    end
    check(ok, "R3 no ack before grant", int'(ok), 1);
    pclk_i = 1'b1;
    tick(4);
    grant_n_i = 1'b0;
    preq_n_i  = 1'b0;
    tick(4);

    // R5/R6 sweep over every byte value, mixed types and stalls
    for (int i = 0; i < 256; i++) send_byte(DW'(i), (i % 3) == 0, i % 4);

    // R7: stop, bus stays off until grant withdrawn
    preq_n_i = 1'b1;
    stop_i = 1'b1;
    k = 0;
    while (rev_req_n_o !== 1'b1 && k < 20) begin tick(1); k++; end
    stop_i = 1'b0;
    check(rev_req_n_o == 1'b1, "R7 request released", int'(rev_req_n_o), 1);
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (data_oe_o) ok = 1'b0;
    end
    check(ok, "R7 bus off while grant held", int'(ok), 1);
    grant_n_i = 1'b1;
    k = 0;
    while (data_oe_o !== 1'b1 && k < 20) begin tick(1); k++; end
    check(k == 3, "R7 bus redriven after grant withdrawn", k, 3);

    // R8: grant never comes, limit 20
    tmo_lim_i = TW'(20);
    pulse_start();
    tick(1);
    k = 0;
    while (err_o !== 1'b1 && k < 100) begin tick(1); k++; end
    check(k >= 19 && k <= 21, "R8 timeout cycles", k, 20);
    check(rev_req_n_o && data_oe_o, "R8 back to forward idle",
          int'({rev_req_n_o, data_oe_o}), 3);

    // R9: sticky, cleared by start
    tick(30);
    check(err_o == 1'b1, "R9 error sticky", int'(err_o), 1);
    pulse_start();
    check(err_o == 1'b0, "R9 error cleared by start", int'(err_o), 0);
    tick(1);
    grant_n_i = 1'b0;
    tick(6);
    check(!err_o && !rev_req_n_o, "R8 no timeout when granted in time",
          int'({err_o, rev_req_n_o}), 0);

    // R8: peripheral claims data but never strobes
    preq_n_i = 1'b0;
    k = 0;
    while (err_o !== 1'b1 && k < 100) begin tick(1); k++; end
    check(err_o == 1'b1 && rev_req_n_o, "R8 timeout waiting for strobe",
          int'({err_o, rev_req_n_o}), 3);
    preq_n_i = 1'b1;
    grant_n_i = 1'b1;
    tick(5);

    // R8: limit zero never expires
    tmo_lim_i = '0;
    pulse_start();
    tick(100);
    check(!err_o && !rev_req_n_o, "R8 zero limit disables timeout",
          int'({err_o, rev_req_n_o}), 0);
    grant_n_i = 1'b0;
    tick(5);
    send_byte(8'hA5, 1'b1, 2);
    stop_i = 1'b1;
    tick(5);
    stop_i = 1'b0;
    grant_n_i = 1'b1;
    tick(6);
    check(data_oe_o && rev_req_n_o, "R7 clean return to forward idle",
          int'({data_oe_o, rev_req_n_o}), 3);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule